// File: doc/BRIEF.md
# Prescaled 16-bit Reference-Compare Timer

This block is one general-purpose timer channel behind a small register interface. A 16-bit up-counter advances on a count tick. The tick comes from a selectable source: an external cascade tick, the core clock, or the core clock divided by 16. The selected source then passes through two 8-bit dividers in series. Software programs the dividers, the source, the reference value and the reaction to a match. It then releases the channel and either polls the event register or waits for the interrupt.

When the count equals the reference on a tick, a reference event is latched. The counter then either returns to zero or keeps counting, as the mode register selects. A synchronized capture strobe copies the running count into a capture register and latches a second event. Events are cleared by writing ones. The usual bring-up sequence is: hold the channel stopped, program the dividers and mode, zero the counter, set the reference, clear every event, then release the stop bit.

Top module: `tmr16_ref`

## Requirements
- R1: After reset every register reads 0x0000 and `irq` is low.
- R2: Mode bits 2:1 pick the count source. 00 counts one per cycle in which `casc_tick` is high, 01 counts the core clock, 10 counts the core clock divided by 16, and 11 never counts.
- R3: The selected source is divided by (P+1)×(S+1). P is the low byte of the prescale register at address 6, and S is mode bits 15:8. The divider state starts from zero when counting is released.
- R4: On a tick where the counter equals the reference, event bit 1 is set. With mode bit 3 set the counter then goes to 0, and with it clear the counter goes to count+1.
- R5: When restart is off, the counter wraps from 0xFFFF to 0x0000. The wrap raises no event unless the reference equals the count at that tick.
- R6: Writing the event register at address 5 clears each bit written as one and leaves the others. A same-cycle event wins over a clear.
- R7: `irq` is high exactly while event bit 1 and mode bit 4 are both set.
- R8: Control bit 1 (stop) freezes the counter and clears the divider state.
- R9: While control bit 0 (enable) is clear, the counter is held at zero and software writes to it are ignored.
- R10: The counter at address 4 is writable while enabled, and a write takes priority over a tick in the same cycle.
- R11: A rising edge on `cap_in`, after a two-stage synchronizer, copies the count into the capture register at address 3 and sets event bit 0.
- R12: Register addresses are: control 0, mode 1, reference 2, capture 3, counter 4, event 5, prescale 6. Unused bits read 0: control keeps bits 1:0, mode keeps bits 15:8 and 4:1, and prescale keeps bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| casc_tick | input | 1 | Cascade count enable, synchronous to `clk` |
| cap_in | input | 1 | Asynchronous capture strobe |
| irq | output | 1 | Reference interrupt request |

## Verification
The counting path is tried with each source setting, including the blocked code, and with two divider pairs. Distinct divider values show whether the factors multiply rather than add, and a divide-by-16 run over exactly three periods shows whether the slow stage resets on stop. Match behaviour is tried with restart on and off against the same reference. A restart run lands mid-period, which separates "zero after match" from "zero at match". Wrap runs near 0xFFFF with a distant reference and with the reference at 0xFFFF separate a true compare from a false event on overflow.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int DW = 16;
    localparam int AW = 3;

    typedef enum logic [1:0] {
        SRC_CASC = 2'b00,
        SRC_CLK  = 2'b01,
        SRC_SLOW = 2'b10,
        SRC_OFF  = 2'b11
    } clk_src_e;

    typedef enum logic [AW-1:0] {
        A_CTRL = 3'd0,
        A_MODE = 3'd1,
        A_REF  = 3'd2,
        A_CAP  = 3'd3,
        A_CNT  = 3'd4,
        A_EVT  = 3'd5,
        A_PSR  = 3'd6
    } reg_addr_e;

    localparam int CTL_EN     = 0;
    localparam int CTL_STOP   = 1;
    localparam int MD_SRC_LO  = 1;
    localparam int MD_RESTART = 3;
    localparam int MD_IRQEN   = 4;
    localparam int MD_SPS_LO  = 8;
    localparam int EV_CAP     = 0;
    localparam int EV_REF     = 1;
endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
    import tmr16_pkg::*;
#(
    parameter int PW       = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  clk_src_e      src_i,
    input  logic          casc_i,
    input  logic [PW-1:0] psr_i,
    input  logic [PW-1:0] sps_i,
    output logic          tick_o
);
    localparam int SW = $clog2(SLOW_DIV);

    typedef struct packed {
        logic [SW-1:0] slow;
        logic [PW-1:0] pri;
        logic [PW-1:0] sec;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic slow_tick, src_tick, pri_wrap, sec_wrap;

    always_comb begin
        st_d      = st_q;
        slow_tick = (st_q.slow == SW'(SLOW_DIV - 1));
        src_tick  = 1'b0;
        case (src_i)
            SRC_CASC: src_tick = casc_i;
            SRC_CLK:  src_tick = 1'b1;
            SRC_SLOW: src_tick = slow_tick;
            default:  src_tick = 1'b0;
        endcase
        pri_wrap = src_tick && (st_q.pri == psr_i);
        sec_wrap = pri_wrap && (st_q.sec == sps_i);
        if (!run_i) begin
            st_d = '0;
        end else begin
            st_d.slow = slow_tick ? '0 : st_q.slow + 1'b1;
            if (src_tick) st_d.pri = pri_wrap ? '0 : st_q.pri + 1'b1;
            if (pri_wrap) st_d.sec = sec_wrap ? '0 : st_q.sec + 1'b1;
        end
    end

    assign tick_o = run_i && sec_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q == '0));
endmodule

// File: rtl/tmr16_capsync.sv
module tmr16_capsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } cs_st_t;

    cs_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], async_i};
        st_d.prev = st_q.sync[STAGES-1];
    end

    assign rise_o = st_q.sync[STAGES-1] && !st_q.prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          run_i,
    input  logic          tick_i,
    input  logic          restart_i,
    input  logic [CW-1:0] ref_i,
    input  logic          cnt_wr_i,
    input  logic [CW-1:0] cnt_wdata_i,
    input  logic [1:0]    evt_clr_i,
    input  logic          cap_rise_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cap_o,
    output logic [1:0]    evt_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cap;
        logic [1:0]    evt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic step, match;

    always_comb begin
        st_d  = st_q;
        step  = active_i && run_i && tick_i;
        match = (st_q.cnt == ref_i);
        st_d.evt = st_q.evt & ~evt_clr_i;
        if (!active_i) begin
            st_d.cnt = '0;
        end else if (cnt_wr_i) begin
            st_d.cnt = cnt_wdata_i;
        end else if (step) begin
            st_d.cnt = (match && restart_i) ? '0 : st_q.cnt + 1'b1;
        end
        if (step && match) st_d.evt[1] = 1'b1;
        if (active_i && cap_rise_i) begin
            st_d.cap    = st_q.cnt;
            st_d.evt[0] = 1'b1;
        end
    end

    assign cnt_o = st_q.cnt;
    assign cap_o = st_q.cap;
    assign evt_o = st_q.evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    ref_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && tick_i && st_q.cnt == ref_i) |=> st_q.evt[1]);
    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && tick_i && !cnt_wr_i && restart_i && st_q.cnt == ref_i) |=> (st_q.cnt == '0));
    // R6
    evt_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr_i[1] && !(tick_i && st_q.cnt == ref_i)) |=> !st_q.evt[1]);
    // R8
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !run_i && !cnt_wr_i) |=> $stable(st_q.cnt));
    // R9
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (st_q.cnt == '0));
    // R11
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && cap_rise_i) |=> (st_q.cap == $past(st_q.cnt) && st_q.evt[0]));
endmodule

// File: rtl/tmr16_ref.sv
module tmr16_ref
    import tmr16_pkg::*;
#(
    parameter int CW       = 16,
    parameter int PW       = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          casc_tick,
    input  logic          cap_in,
    output logic          irq
);
    typedef struct packed {
        logic          en;
        logic          stop;
        clk_src_e      src;
        logic          restart;
        logic          irq_en;
        logic [PW-1:0] sps;
        logic [PW-1:0] psr;
        logic [CW-1:0] refv;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic          tick, cap_rise, cnt_wr;
    logic [1:0]    evt_clr, evt;
    logic [CW-1:0] cnt, cap;

    always_comb begin
        cfg_d   = cfg_q;
        cnt_wr  = 1'b0;
        evt_clr = '0;
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    cfg_d.en   = wdata[CTL_EN];
                    cfg_d.stop = wdata[CTL_STOP];
                end
                A_MODE: begin
                    cfg_d.src     = clk_src_e'(wdata[MD_SRC_LO +: 2]);
                    cfg_d.restart = wdata[MD_RESTART];
                    cfg_d.irq_en  = wdata[MD_IRQEN];
                    cfg_d.sps     = wdata[MD_SPS_LO +: PW];
                end
                A_REF: cfg_d.refv = wdata[CW-1:0];
                A_CNT: cnt_wr = 1'b1;
                A_EVT: evt_clr = wdata[1:0];
                A_PSR: cfg_d.psr = wdata[PW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CTL_EN]   = cfg_q.en;
                rdata[CTL_STOP] = cfg_q.stop;
            end
            A_MODE: begin
                rdata[MD_SRC_LO +: 2]  = cfg_q.src;
                rdata[MD_RESTART]      = cfg_q.restart;
                rdata[MD_IRQEN]        = cfg_q.irq_en;
                rdata[MD_SPS_LO +: PW] = cfg_q.sps;
            end
            A_REF: rdata[CW-1:0] = cfg_q.refv;
            A_CAP: rdata[CW-1:0] = cap;
            A_CNT: rdata[CW-1:0] = cnt;
            A_EVT: rdata[1:0]    = evt;
            A_PSR: rdata[PW-1:0] = cfg_q.psr;
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    tmr16_prescale #(.PW(PW), .SLOW_DIV(SLOW_DIV)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (cfg_q.en && !cfg_q.stop),
        .src_i  (cfg_q.src),
        .casc_i (casc_tick),
        .psr_i  (cfg_q.psr),
        .sps_i  (cfg_q.sps),
        .tick_o (tick)
    );

    tmr16_capsync #(.STAGES(2)) u_capsync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cap_in),
        .rise_o  (cap_rise)
    );

    tmr16_core #(.CW(CW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (cfg_q.en),
        .run_i       (!cfg_q.stop),
        .tick_i      (tick),
        .restart_i   (cfg_q.restart),
        .ref_i       (cfg_q.refv),
        .cnt_wr_i    (cnt_wr),
        .cnt_wdata_i (wdata[CW-1:0]),
        .evt_clr_i   (evt_clr),
        .cap_rise_i  (cap_rise),
        .cnt_o       (cnt),
        .cap_o       (cap),
        .evt_o       (evt)
    );

    assign irq = evt[EV_REF] && cfg_q.irq_en;

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_EVT && wdata[EV_REF] && !tick) |=> !irq);
endmodule

// File: tb/tmr16_ref_test.sv
`timescale 1ns/1ps
module tmr16_ref_test;
    import tmr16_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        casc_tick = 1'b0;
    logic        cap_in = 1'b0;
    logic        irq;

    typedef struct {
        logic [15:0] exp;
        bit          is_irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    event smp;

    tmr16_ref uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .casc_tick(casc_tick), .cap_in(cap_in), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // monitor: pops expectations and compares against the ports
    always @(smp) begin
        while (q.size() > 0) begin
            exp_t e;
            logic [15:0] act;
            e = q.pop_front();
            act = e.is_irq ? {15'd0, irq} : rdata;
            checks++;
            if (act !== e.exp) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", e.tag, act, e.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1;
        q.push_back('{e, 1'b0, tag});
        ->smp;
        #0.5;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        #1;
        q.push_back('{{15'd0, e}, 1'b1, tag});
        ->smp;
        #0.5;
    endtask

    // release stop for exactly n core cycles (n >= 2), then stop again
    task automatic run_cycles(input int n);
        wr(A_CTRL, 16'h0001);
        repeat (n - 2) @(negedge clk);
        wr(A_CTRL, 16'h0003);
    endtask

    task automatic setup(input logic [15:0] mode, input logic [15:0] psr,
                         input logic [15:0] refv, input logic [15:0] cnt);
        wr(A_CTRL, 16'h0003);
        wr(A_PSR, psr);
        wr(A_MODE, mode);
        wr(A_CNT, cnt);
        wr(A_REF, refv);
        wr(A_EVT, 16'hFFFF);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_reg(A_CTRL, 16'h0000, "R1 ctrl");
        chk_reg(A_MODE, 16'h0000, "R1 mode");
        chk_reg(A_CNT,  16'h0000, "R1 cnt");
        chk_reg(A_EVT,  16'h0000, "R1 evt");
        chk_irq(1'b0, "R1 irq");

        // R12 readback masks
        wr(A_MODE, 16'hFFFF);
        chk_reg(A_MODE, 16'hFF1E, "R12 mode mask");
        wr(A_PSR, 16'hFFFF);
        chk_reg(A_PSR, 16'h00FF, "R12 psr mask");
        wr(A_CTRL, 16'hFFFF);
        chk_reg(A_CTRL, 16'h0003, "R12 ctrl mask");

        // R2 core clock, no division
        setup(16'h0002, 16'h0000, 16'h0100, 16'h0000);
        run_cycles(10);
        chk_reg(A_CNT, 16'd10, "R2 clk source");

        // R2 blocked source code
        setup(16'h0006, 16'h0000, 16'h0100, 16'h0000);
        run_cycles(10);
        chk_reg(A_CNT, 16'd0, "R2 src 11 no count");

        // R3 prescale 3*2 = 6
        setup(16'h0102, 16'h0002, 16'h0100, 16'h0000);
        run_cycles(30);
        chk_reg(A_CNT, 16'd5, "R3 psr2 sps1");
        run_cycles(11);
        chk_reg(A_CNT, 16'd6, "R3 divider restarts after stop");

        // R2 slow clock /16
        setup(16'h0004, 16'h0000, 16'h0100, 16'h0000);
        run_cycles(48);
        chk_reg(A_CNT, 16'd3, "R2 slow go");

        // R2 cascade source
        setup(16'h0000, 16'h0000, 16'h0100, 16'h0000);
        wr(A_CTRL, 16'h0001);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); casc_tick = 1'b1;
            @(negedge clk); casc_tick = 1'b0;
        end
        wr(A_CTRL, 16'h0003);
        chk_reg(A_CNT, 16'd4, "R2 cascade");

        // R4 restart on match, R7 irq enabled
        setup(16'h001A, 16'h0000, 16'h0003, 16'h0000);
        run_cycles(10);
        chk_reg(A_CNT, 16'd2, "R4 restart count");
        chk_reg(A_EVT, 16'h0002, "R4 ref event");
        chk_irq(1'b1, "R7 irq high");

        // R6 write-one-to-clear
        wr(A_EVT, 16'h0001);
        chk_reg(A_EVT, 16'h0002, "R6 other bit kept");
        chk_irq(1'b1, "R7 irq kept");
        wr(A_EVT, 16'h0002);
        chk_reg(A_EVT, 16'h0000, "R6 cleared");
        chk_irq(1'b0, "R7 irq low");

        // R4 free run past reference, R7 irq disabled
        setup(16'h0002, 16'h0000, 16'h0003, 16'h0000);
        run_cycles(10);
        chk_reg(A_CNT, 16'd10, "R4 free run");
        chk_reg(A_EVT, 16'h0002, "R4 free run event");
        chk_irq(1'b0, "R7 irq masked");

        // R8 stop freezes
        repeat (20) @(negedge clk);
        chk_reg(A_CNT, 16'd10, "R8 frozen");

        // R5 wrap without event
        setup(16'h0002, 16'h0000, 16'h0005, 16'hFFFE);
        run_cycles(3);
        chk_reg(A_CNT, 16'h0001, "R5 wrap");
        chk_reg(A_EVT, 16'h0000, "R5 no event on wrap");
        // R5 reference at top
        setup(16'h0002, 16'h0000, 16'hFFFF, 16'hFFFE);
        run_cycles(2);
        chk_reg(A_CNT, 16'h0000, "R5 wrap at ref");
        chk_reg(A_EVT, 16'h0002, "R5 event at FFFF");

        // R10 write beats tick
        setup(16'h0002, 16'h0000, 16'h0800, 16'h0000);
        wr(A_CTRL, 16'h0001);
        wr(A_CNT, 16'h0100);
        wr(A_CTRL, 16'h0003);
        chk_reg(A_CNT, 16'h0102, "R10 write while running");

        // R9 enable clear holds zero, ignores writes
        wr(A_CTRL, 16'h0000);
        chk_reg(A_CNT, 16'h0000, "R9 held zero");
        wr(A_CNT, 16'h0005);
        chk_reg(A_CNT, 16'h0000, "R9 write ignored");

        // R11 capture
        setup(16'h0012, 16'h0000, 16'h0800, 16'h1234);
        @(negedge clk); cap_in = 1'b1;
        repeat (5) @(negedge clk);
        chk_reg(A_CAP, 16'h1234, "R11 capture value");
        chk_reg(A_EVT, 16'h0001, "R11 capture event");
        chk_irq(1'b0, "R7 capture no irq");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule